// File: doc/BRIEF.md
# Burst Address Generator with Sequence Mode Select

This block drives the address bus of a synchronous burst SRAM array. When a burst opens, it captures a full external address into an output register. After that it produces up to three more addresses by itself. Each of those comes one clock after a request on the step input. Only the two lowest address bits move during a burst. The upper bits stay at the value captured at the start.

Two strobes can open a burst. The processor-side strobe takes effect only while the chip-select input is active. The controller-side strobe always takes effect. A mode input chooses how the low bits advance:

- **Linear:** the low bits count up from the start value and wrap modulo four.
- **Interleaved:** the low bits are the start value XORed with a step index that runs 0, 1, 2, 3.

After four addresses either sequence is back at its start value, and the burst continues from there. No end-of-burst indication is produced. When no strobe and no step is active, the register holds its value, which suspends the burst.

All strobes are active-low and are sampled on the rising clock edge. The address output is registered.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, and after its release until the first load, addr_o is all zeros.
- R2: When ctl_start_ni is low at a rising edge, addr_o equals addr_i one cycle later. This holds whatever the levels of cpu_start_ni and chip_sel_ni.
- R3: When cpu_start_ni and chip_sel_ni are both low at a rising edge, addr_i is loaded. When cpu_start_ni is low but chip_sel_ni is high, nothing is loaded.
- R4: A step (step_ni low with no load) leaves every bit of addr_o above bit 1 unchanged.
- R5: With seq_mode_i = 0 (linear), the n-th step after a load sets addr_o[1:0] to (start + n) mod 4.
- R6: With seq_mode_i = 1 (interleaved), the n-th step after a load sets addr_o[1:0] to start XOR (n mod 4). For example, a start of 1 gives 1, 0, 3, 2.
- R7: With no load and step_ni high, addr_o keeps its value, and a later step resumes the sequence where it stopped.
- R8: The fourth step after a load returns addr_o to the start address, and stepping continues around the same cycle.
- R9: A load at a rising edge takes priority over a simultaneous step and restarts the step index at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active-low |
| addr_i | input | ADDR_W | External start address |
| cpu_start_ni | input | 1 | Processor-side burst start, active-low, gated by chip select |
| ctl_start_ni | input | 1 | Controller-side burst start, active-low, ungated |
| chip_sel_ni | input | 1 | Chip select, active-low |
| step_ni | input | 1 | Advance to the next burst address, active-low |
| seq_mode_i | input | 1 | 0 selects the linear sequence, 1 the interleaved sequence |
| addr_o | output | ADDR_W | Registered array address |

## Verification
A corrupt step index or captured base does not change the port at once. It appears on addr_o[1:0] at the first step after the fault, one cycle after step_ni is sampled low. When the burst is suspended, the error stays hidden until stepping resumes. A wrong priority or a wrong chip-select gating shows up in the cycle after the strobe edge: the address is wrongly loaded or wrongly held. Comparing every address over full four-step bursts in both modes, including a wrap and a pause in the middle of a burst, therefore exposes index faults within at most four steps.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic {
    SEQ_LINEAR     = 1'b0,
    SEQ_INTERLEAVE = 1'b1
  } seq_mode_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_STEP = 2'd2
  } bag_act_e;
endpackage

// File: rtl/bag_start_decode.sv
module bag_start_decode
  import bag_pkg::*;
(
  input  logic     cpu_start_ni,
  input  logic     ctl_start_ni,
  input  logic     chip_sel_ni,
  input  logic     step_ni,
  output bag_act_e act_o
);
  logic cpu_load, ctl_load;

  assign cpu_load = !cpu_start_ni && !chip_sel_ni;
  assign ctl_load = !ctl_start_ni;

  // load beats step
  always_comb begin
    if (cpu_load || ctl_load) act_o = ACT_LOAD;
    else if (!step_ni)        act_o = ACT_STEP;
    else                      act_o = ACT_HOLD;
  end
endmodule

// File: rtl/bag_counter.sv
module bag_counter
  import bag_pkg::*;
#(
  parameter int unsigned BURST_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  bag_act_e           act_i,
  output logic [BURST_W-1:0] cnt_nxt_o
);
  logic [BURST_W-1:0] cnt_q;

  assign cnt_nxt_o = cnt_q + BURST_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (act_i == ACT_LOAD) cnt_q <= '0;
    else if (act_i == ACT_STEP) cnt_q <= cnt_nxt_o;
  end

  // R9: load restarts the index at zero
  a_r9_load_clears_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_LOAD) |=> (cnt_q == '0));
endmodule

// File: rtl/bag_seq_map.sv
module bag_seq_map
  import bag_pkg::*;
#(
  parameter int unsigned BURST_W = 2
) (
  input  logic [BURST_W-1:0] base_i,
  input  logic [BURST_W-1:0] idx_i,
  input  seq_mode_e          mode_i,
  output logic [BURST_W-1:0] lo_o
);
  logic [BURST_W-1:0] lin, ilv;

  assign lin = base_i + idx_i;

  for (genvar b = 0; b < BURST_W; b++) begin : g_ilv
    assign ilv[b] = base_i[b] ^ idx_i[b];
  end

  assign lo_o = (mode_i == SEQ_INTERLEAVE) ? ilv : lin;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cpu_start_ni,
  input  logic              ctl_start_ni,
  input  logic              chip_sel_ni,
  input  logic              step_ni,
  input  logic              seq_mode_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned HI_W = ADDR_W - BURST_W;

  bag_act_e           act;
  logic [BURST_W-1:0] idx_nxt, lo_nxt, base_lo_q;
  logic [ADDR_W-1:0]  addr_q;
  seq_mode_e          mode;

  assign mode = seq_mode_e'(seq_mode_i);

  bag_start_decode u_dec (
    .cpu_start_ni (cpu_start_ni),
    .ctl_start_ni (ctl_start_ni),
    .chip_sel_ni  (chip_sel_ni),
    .step_ni      (step_ni),
    .act_o        (act)
  );

  bag_counter #(.BURST_W(BURST_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (act),
    .cnt_nxt_o (idx_nxt)
  );

  bag_seq_map #(.BURST_W(BURST_W)) u_map (
    .base_i (base_lo_q),
    .idx_i  (idx_nxt),
    .mode_i (mode),
    .lo_o   (lo_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      base_lo_q <= '0;
    end else if (act == ACT_LOAD) begin
      addr_q    <= addr_i;
      base_lo_q <= addr_i[BURST_W-1:0];
    end else if (act == ACT_STEP) begin
      addr_q[BURST_W-1:0] <= lo_nxt;
    end
  end

  assign addr_o = addr_q;

  a_r2_ctl_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_start_ni |=> (addr_o == $past(addr_i)));

  a_r3_cpu_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_start_ni && chip_sel_ni && ctl_start_ni && step_ni) |=> $stable(addr_o));

  a_r4_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_start_ni || chip_sel_ni) && ctl_start_ni |=> $stable(addr_o[ADDR_W-1:BURST_W]));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cpu_start_ni || chip_sel_ni) && ctl_start_ni && step_ni) |=> $stable(addr_o));

  initial begin
    a_r1_width_ok: assert (HI_W > 0);
  end
endmodule

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;
  localparam int unsigned AW = 18;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          cpu_start_ni = 1'b1, ctl_start_ni = 1'b1, chip_sel_ni = 1'b1;
  logic          step_ni = 1'b1, seq_mode_i = 1'b0;
  logic [AW-1:0] addr_o;

  int checks = 0, errors = 0;
  logic [AW-1:0] exp_q[$];
  string         req_q[$];

  logic [AW-1:0] m_addr = '0;
  logic [1:0]    m_base = '0, m_idx = '0;
  bit            done = 0;

  burst_addr_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i),
    .cpu_start_ni(cpu_start_ni), .ctl_start_ni(ctl_start_ni),
    .chip_sel_ni(chip_sel_ni), .step_ni(step_ni),
    .seq_mode_i(seq_mode_i), .addr_o(addr_o)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: addr_o=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected address
  task automatic cyc(input string req, input bit cpu, input bit ctl, input bit cs,
                     input bit stp, input bit mode, input logic [AW-1:0] a);
    @(negedge clk);
    cpu_start_ni = cpu; ctl_start_ni = ctl; chip_sel_ni = cs;
    step_ni = stp; seq_mode_i = mode; addr_i = a;
    if (!ctl || (!cpu && !cs)) begin
      m_addr = a; m_base = a[1:0]; m_idx = 2'd0;
    end else if (!stp) begin
      m_idx = m_idx + 2'd1;
      m_addr[1:0] = mode ? (m_base ^ m_idx) : (m_base + m_idx);
    end
    exp_q.push_back(m_addr);
    req_q.push_back(req);
  endtask

  // monitor
  always @(posedge clk) begin
    #5;
    if (rst_ni && exp_q.size() > 0) check(req_q.pop_front(), addr_o, exp_q.pop_front());
  end

  initial begin
    #200000000;
    errors++; checks++;
    $display("FAIL watchdog: addr_o=%h expected=done", addr_o);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #35; check("R1 in reset", addr_o, '0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk); check("R1 after release", addr_o, '0);

    // linear burst via controller strobe, start low bits 1
    cyc("R2 ctl load", 1, 0, 1, 1, 0, 18'h12345);
    cyc("R5 linear n1", 1, 1, 1, 0, 0, 18'h3FFFF);
    cyc("R5 linear n2", 1, 1, 1, 0, 0, 18'h00000);
    cyc("R7 pause", 1, 1, 1, 1, 0, 18'h00000);
    cyc("R7 pause 2", 1, 0 ^ 1, 1, 1, 0, 18'h11111);
    cyc("R5 linear n3 resumed", 1, 1, 1, 0, 0, 18'h0);
    cyc("R8 linear wrap", 1, 1, 1, 0, 0, 18'h0);
    cyc("R4 R5 continue", 1, 1, 1, 0, 0, 18'h0);

    // interleaved burst via processor strobe, start low bits 2
    cyc("R3 cpu load", 0, 1, 0, 1, 1, 18'h2ABCE);
    cyc("R6 ilv n1", 1, 1, 0, 0, 1, 18'h0);
    cyc("R6 ilv n2", 1, 1, 0, 0, 1, 18'h0);
    cyc("R6 ilv n3", 1, 1, 0, 0, 1, 18'h0);
    cyc("R8 ilv wrap", 1, 1, 0, 0, 1, 18'h0);

    // processor strobe without chip select
    cyc("R3 cpu gated", 0, 1, 1, 1, 1, 18'h01234);
    cyc("R3 gated step", 0, 1, 1, 0, 1, 18'h01234);

    // controller strobe ignores processor strobe and chip select
    cyc("R2 ctl with cpu", 0, 0, 1, 1, 1, 18'h15551);
    cyc("R6 ilv start1 n1", 1, 1, 1, 0, 1, 18'h0);
    cyc("R6 ilv start1 n2", 1, 1, 1, 0, 1, 18'h0);
    cyc("R6 ilv start1 n3", 1, 1, 1, 0, 1, 18'h0);

    // priority of load over step
    cyc("R9 ctl over step", 1, 0, 1, 0, 0, 18'h20003);
    cyc("R9 index restarted", 1, 1, 1, 0, 0, 18'h0);
    cyc("R9 cpu over step", 0, 1, 0, 0, 0, 18'h3C3C2);
    cyc("R9 index restarted 2", 1, 1, 1, 0, 0, 18'h0);
    cyc("R5 linear from 2", 1, 1, 1, 0, 0, 18'h0);

    cyc("R7 idle", 1, 1, 1, 1, 0, 18'h0);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule